// File: doc/BRIEF.md
# Anchoring Backlog Queue with Admission Control and Circuit Breaker

This block sits between a fast local commit lane and a slow external anchoring lane. Each time the fast lane finishes a local commit it offers the entry's hash. The block stores the hash in an internal ring. A drain controller then sends the stored hashes, oldest first, toward an external anchor sink. The sink is a valid/ready interface that also carries a health flag. Hashes leave in batches, and the last beat of each batch is marked. After every batch the controller waits a fixed number of cycles, which limits the rate toward the sink.

The fast lane is never stalled by the slow lane. Queue occupancy is the only thing that can refuse a commit. When the number of pending entries reaches an admission limit, the commit is turned away with a back-off indication. When the backlog rises above a high-water mark, the batch size doubles, which spreads the fixed inter-batch gap over more entries. When the backlog drains below a low-water mark, the batch size returns to its minimum.

The sink can refuse beats or stop answering. After a run of consecutive failures a circuit breaker opens and stops all traffic toward the sink. Stored entries are kept while the breaker is open. After a cooldown the breaker sends a single probe entry. A good probe closes the breaker; a failed probe starts a new cooldown. Two sticky flags record that a commit was ever refused and that the breaker ever opened.

Top module: `anchor_backlog_queue`

## Requirements
- R1: A commit with `commit_valid` high is accepted (`commit_accept` high) whenever `pending_count` is below ADMIT_LIMIT. This holds regardless of breaker state and sink health. An accepted hash is stored, and `pending_count` rises by one at the next clock edge unless a beat leaves in the same cycle.
- R2: A commit offered while `pending_count` is at or above ADMIT_LIMIT raises `commit_backoff` and not `commit_accept`, and its hash is not stored. From the next cycle `overflow_seen` is high and stays high until reset.
- R3: `anchor_hash` always presents the oldest stored hash. A beat completes only in a cycle where `anchor_valid`, `anchor_ready` and `anchor_healthy` are all high, and that hash is then removed. `pending_count` equals the number of stored hashes.
- R4: With the breaker closed and no batch in progress, a stored entry makes a batch start in the following cycle. The batch holds min(`batch_size`, `pending_count`) beats, with both values taken in the launch cycle. `anchor_last` is high on the final beat only. After the final beat completes, `anchor_valid` stays low for GAP_CYCLES+1 cycles.
- R5: `batch_size` resets to BATCH_MIN. Each cycle it is updated from that cycle's `pending_count`, and the new value is visible in the next cycle. At or above HIGH_WM it doubles, saturating at BATCH_MAX. At or below LOW_WM it returns to BATCH_MIN. Otherwise it holds. BATCH_MIN and BATCH_MAX are powers of two.
- R6: A presented beat fails in either of two cases: `anchor_ready` is high while `anchor_healthy` is low, or `anchor_valid` has been held for TIMEOUT cycles without `anchor_ready`. A failed beat keeps its entry, and the same hash is presented again.
- R7: FAIL_LIMIT consecutive failures open the breaker: `breaker_open` rises, `anchor_valid` drops, and `breaker_tripped` rises and stays high until reset. A completed beat clears the failure run. Stored entries are held while the breaker is open.
- R8: After COOLDOWN cycles open, the breaker presents one probe beat with `anchor_last` high, while `breaker_open` stays high. A completed probe closes the breaker and normal batching resumes. A failed probe restarts the cooldown.
- R9: After reset `pending_count` is 0, `batch_size` is BATCH_MIN, and `anchor_valid`, `breaker_open`, `overflow_seen` and `breaker_tripped` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_valid | input | 1 | Fast lane offers a committed entry |
| commit_hash | input | HASH_W | Hash of the offered entry |
| commit_accept | output | 1 | Entry admitted this cycle |
| commit_backoff | output | 1 | Entry refused; requester must back off |
| anchor_valid | output | 1 | Beat presented to the anchor sink |
| anchor_hash | output | HASH_W | Oldest pending hash |
| anchor_last | output | 1 | Final beat of a batch or the probe beat |
| anchor_ready | input | 1 | Sink takes the beat this cycle |
| anchor_healthy | input | 1 | Sink health; low with ready means a refused beat |
| pending_count | output | $clog2(DEPTH+1) | Entries waiting for anchoring |
| batch_size | output | $clog2(BATCH_MAX+1) | Current batch length |
| breaker_open | output | 1 | Breaker open or half-open |
| overflow_seen | output | 1 | Sticky: a commit was refused |
| breaker_tripped | output | 1 | Sticky: the breaker has opened |

## Verification
The bench builds the block with an 8-entry ring, an admission limit of 6, water marks of 5 and 1, batches from 1 to 4 beats, a 2-cycle gap, a 4-cycle ready timeout, a failure limit of 3 and a 6-cycle cooldown. These small values let a burst of a few cycles reach the admission limit and force refusals. They also let the batch size double twice and saturate, and let timeouts, breaker trips, failed probes and successful probes each happen many times within a few thousand cycles. A behavioural model built from an ordinary queue and integers predicts every output on every cycle. It is run through directed phases for healthy, refusing and silent sinks, and then through a long pseudo-random phase.

// File: rtl/anchq_pkg.sv
package anchq_pkg;
    typedef enum logic [2:0] {
        DR_IDLE,
        DR_SEND,
        DR_GAP,
        DR_OPEN,
        DR_PROBE
    } drain_state_e;
endpackage

// File: rtl/hash_ring.sv
// Circular store of pending hashes; DEPTH must be a power of two.
module hash_ring #(
    parameter int HASH_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [HASH_W-1:0] push_data,
    input  logic              pop,
    output logic [HASH_W-1:0] head,
    output logic [CW-1:0]     count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [HASH_W-1:0] slot_q [DEPTH];

    always_comb begin
        ring_d     = ring_q;
        ring_d.wr  = ring_q.wr + AW'(push);
        ring_d.rd  = ring_q.rd + AW'(pop);
        ring_d.cnt = ring_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[ring_q.wr] <= push_data;
    end

    assign head  = slot_q[ring_q.rd];
    assign count = ring_q.cnt;
endmodule

// File: rtl/batch_sizer.sv
// Batch length follows backlog: doubles above the high mark, resets below the low mark.
module batch_sizer #(
    parameter int CW        = 5,
    parameter int BW        = 4,
    parameter int BATCH_MIN = 2,
    parameter int BATCH_MAX = 8,
    parameter int HIGH_WM   = 8,
    parameter int LOW_WM    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    output logic [BW-1:0] batch
);
    typedef struct packed {
        logic [BW-1:0] len;
    } sizer_t;

    sizer_t sz_d, sz_q;

    always_comb begin
        sz_d = sz_q;
        if (count >= CW'(HIGH_WM)) begin
            if (sz_q.len >= BW'(BATCH_MAX / 2)) sz_d.len = BW'(BATCH_MAX);
            else                                sz_d.len = sz_q.len << 1;
        end else if (count <= CW'(LOW_WM)) begin
            sz_d.len = BW'(BATCH_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sz_q.len <= BW'(BATCH_MIN);
        else        sz_q     <= sz_d;
    end

    assign batch = sz_q.len;
endmodule

// File: rtl/drain_ctrl.sv
// Slow-lane drain: batches, inter-batch gap, failure counting, breaker with probe.
module drain_ctrl
    import anchq_pkg::*;
#(
    parameter int CW         = 5,
    parameter int BW         = 4,
    parameter int GAP_CYCLES = 2,
    parameter int TIMEOUT    = 8,
    parameter int FAIL_LIMIT = 3,
    parameter int COOLDOWN   = 32,
    localparam int WTW = $clog2(TIMEOUT + 1),
    localparam int FW  = $clog2(FAIL_LIMIT + 1),
    localparam int CDW = $clog2(COOLDOWN + 1),
    localparam int GW  = $clog2(GAP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [BW-1:0] batch,
    input  logic          ready,
    input  logic          healthy,
    output logic          valid,
    output logic          last,
    output logic          pop,
    output logic          open,
    output logic          trip
);
    typedef struct packed {
        drain_state_e   st;
        logic [BW-1:0]  beats;
        logic [WTW-1:0] waited;
        logic [FW-1:0]  fails;
        logic [CDW-1:0] cool;
        logic [GW-1:0]  gap;
    } drain_t;

    drain_t dr_d, dr_q;
    logic   beat_ok, beat_fail;

    always_comb begin
        valid     = (dr_q.st == DR_SEND) || (dr_q.st == DR_PROBE && count != '0);
        last      = (dr_q.st == DR_PROBE) || (dr_q.st == DR_SEND && dr_q.beats == BW'(1));
        beat_ok   = valid && ready && healthy;
        beat_fail = valid && ((ready && !healthy) ||
                              (!ready && dr_q.waited == WTW'(TIMEOUT - 1)));
        pop       = beat_ok;
        trip      = 1'b0;
        dr_d      = dr_q;

        if (!valid || ready || beat_fail) dr_d.waited = '0;
        else                              dr_d.waited = dr_q.waited + WTW'(1);

        case (dr_q.st)
            DR_IDLE: begin
                if (count != '0) begin
                    dr_d.st    = DR_SEND;
                    dr_d.beats = (int'(count) < int'(batch)) ? BW'(count) : batch;
                end
            end
            DR_SEND: begin
                if (beat_ok) begin
                    dr_d.fails = '0;
                    if (dr_q.beats == BW'(1)) begin
                        dr_d.st  = DR_GAP;
                        dr_d.gap = GW'(GAP_CYCLES);
                    end else begin
                        dr_d.beats = dr_q.beats - BW'(1);
                    end
                end else if (beat_fail) begin
                    if (dr_q.fails == FW'(FAIL_LIMIT - 1)) begin
                        dr_d.st    = DR_OPEN;
                        dr_d.cool  = CDW'(COOLDOWN);
                        dr_d.fails = '0;
                        trip       = 1'b1;
                    end else begin
                        dr_d.fails = dr_q.fails + FW'(1);
                    end
                end
            end
            DR_GAP: begin
                if (dr_q.gap == GW'(1)) dr_d.st  = DR_IDLE;
                else                    dr_d.gap = dr_q.gap - GW'(1);
            end
            DR_OPEN: begin
                if (dr_q.cool == CDW'(1)) dr_d.st   = DR_PROBE;
                else                      dr_d.cool = dr_q.cool - CDW'(1);
            end
            DR_PROBE: begin
                if (beat_ok) begin
                    dr_d.st = DR_IDLE;
                end else if (beat_fail) begin
                    dr_d.st   = DR_OPEN;
                    dr_d.cool = CDW'(COOLDOWN);
                    trip      = 1'b1;
                end
            end
            default: dr_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q    <= '0;
            dr_q.st <= DR_IDLE;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign open = (dr_q.st == DR_OPEN) || (dr_q.st == DR_PROBE);
endmodule

// File: rtl/anchor_backlog_queue.sv
module anchor_backlog_queue #(
    parameter int HASH_W      = 32,
    parameter int DEPTH       = 16,
    parameter int ADMIT_LIMIT = 12,
    parameter int HIGH_WM     = 8,
    parameter int LOW_WM      = 2,
    parameter int BATCH_MIN   = 2,
    parameter int BATCH_MAX   = 8,
    parameter int GAP_CYCLES  = 2,
    parameter int TIMEOUT     = 8,
    parameter int FAIL_LIMIT  = 3,
    parameter int COOLDOWN    = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int BW = $clog2(BATCH_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_valid,
    input  logic [HASH_W-1:0] commit_hash,
    output logic              commit_accept,
    output logic              commit_backoff,
    output logic              anchor_valid,
    output logic [HASH_W-1:0] anchor_hash,
    output logic              anchor_last,
    input  logic              anchor_ready,
    input  logic              anchor_healthy,
    output logic [CW-1:0]     pending_count,
    output logic [BW-1:0]     batch_size,
    output logic              breaker_open,
    output logic              overflow_seen,
    output logic              breaker_tripped
);
    typedef struct packed {
        logic ovf;
        logic tripped;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   pop, trip;

    // Admission depends on occupancy only, never on slow-lane state.
    always_comb begin
        commit_accept  = commit_valid && (pending_count < CW'(ADMIT_LIMIT));
        commit_backoff = commit_valid && !commit_accept;
        fl_d           = fl_q;
        if (commit_backoff) fl_d.ovf     = 1'b1;
        if (trip)           fl_d.tripped = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign overflow_seen   = fl_q.ovf;
    assign breaker_tripped = fl_q.tripped;

    hash_ring #(.HASH_W(HASH_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit_accept),
        .push_data (commit_hash),
        .pop       (pop),
        .head      (anchor_hash),
        .count     (pending_count)
    );

    batch_sizer #(
        .CW(CW), .BW(BW), .BATCH_MIN(BATCH_MIN), .BATCH_MAX(BATCH_MAX),
        .HIGH_WM(HIGH_WM), .LOW_WM(LOW_WM)
    ) u_sizer (
        .clk   (clk),
        .rst_n (rst_n),
        .count (pending_count),
        .batch (batch_size)
    );

    drain_ctrl #(
        .CW(CW), .BW(BW), .GAP_CYCLES(GAP_CYCLES), .TIMEOUT(TIMEOUT),
        .FAIL_LIMIT(FAIL_LIMIT), .COOLDOWN(COOLDOWN)
    ) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (pending_count),
        .batch   (batch_size),
        .ready   (anchor_ready),
        .healthy (anchor_healthy),
        .valid   (anchor_valid),
        .last    (anchor_last),
        .pop     (pop),
        .open    (breaker_open),
        .trip    (trip)
    );
endmodule

// File: rtl/anchq_checker.sv
module anchq_checker #(
    parameter int HASH_W      = 32,
    parameter int CW          = 5,
    parameter int BW          = 4,
    parameter int ADMIT_LIMIT = 12,
    parameter int BATCH_MIN   = 2,
    parameter int BATCH_MAX   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_accept,
    input logic              commit_backoff,
    input logic              anchor_valid,
    input logic [HASH_W-1:0] anchor_hash,
    input logic              anchor_ready,
    input logic              anchor_healthy,
    input logic [CW-1:0]     pending_count,
    input logic [BW-1:0]     batch_size,
    input logic              breaker_open,
    input logic              overflow_seen,
    input logic              breaker_tripped
);
    logic beat_done;
    assign beat_done = anchor_valid && anchor_ready && anchor_healthy;

    AST_PENDING_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_accept && !beat_done) |=> pending_count == $past(pending_count) + CW'(1)); // R1

    AST_ADMIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_count >= CW'(ADMIT_LIMIT)) |=> pending_count <= $past(pending_count)); // R2

    AST_BACKOFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_backoff |=> overflow_seen); // R2

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_seen |=> overflow_seen); // R2

    AST_BEAT_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !commit_accept) |=> pending_count == $past(pending_count) - CW'(1)); // R3

    AST_BATCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (batch_size >= BW'(BATCH_MIN)) && (batch_size <= BW'(BATCH_MAX)) &&
        ($countones(batch_size) == 1)); // R5

    AST_RETRY_SAME_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        (anchor_valid && !(anchor_ready && anchor_healthy)) |=>
        (!anchor_valid || $stable(anchor_hash))); // R6

    AST_OPEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(breaker_open) |-> (!anchor_valid && breaker_tripped)); // R7

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        breaker_tripped |=> breaker_tripped); // R7
endmodule

bind anchor_backlog_queue anchq_checker #(
    .HASH_W(HASH_W), .CW(CW), .BW(BW), .ADMIT_LIMIT(ADMIT_LIMIT),
    .BATCH_MIN(BATCH_MIN), .BATCH_MAX(BATCH_MAX)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .commit_accept   (commit_accept),
    .commit_backoff  (commit_backoff),
    .anchor_valid    (anchor_valid),
    .anchor_hash     (anchor_hash),
    .anchor_ready    (anchor_ready),
    .anchor_healthy  (anchor_healthy),
    .pending_count   (pending_count),
    .batch_size      (batch_size),
    .breaker_open    (breaker_open),
    .overflow_seen   (overflow_seen),
    .breaker_tripped (breaker_tripped)
);

// File: tb/anchor_backlog_queue_test.sv
`timescale 1ns/1ps
module anchor_backlog_queue_test;
    localparam int HW   = 16;
    localparam int DP   = 8;
    localparam int AL   = 6;
    localparam int HWM  = 5;
    localparam int LWM  = 1;
    localparam int BMIN = 1;
    localparam int BMAX = 4;
    localparam int GAPC = 2;
    localparam int TMO  = 4;
    localparam int FLIM = 3;
    localparam int CD   = 6;
    localparam int CW   = $clog2(DP + 1);
    localparam int BW   = $clog2(BMAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit_valid = 1'b0;
    logic [HW-1:0] commit_hash = '0;
    logic          commit_accept, commit_backoff;
    logic          anchor_valid, anchor_last;
    logic [HW-1:0] anchor_hash;
    logic          anchor_ready = 1'b0;
    logic          anchor_healthy = 1'b0;
    logic [CW-1:0] pending_count;
    logic [BW-1:0] batch_size;
    logic          breaker_open, overflow_seen, breaker_tripped;

    always #10 clk = ~clk;

    anchor_backlog_queue #(
        .HASH_W(HW), .DEPTH(DP), .ADMIT_LIMIT(AL), .HIGH_WM(HWM), .LOW_WM(LWM),
        .BATCH_MIN(BMIN), .BATCH_MAX(BMAX), .GAP_CYCLES(GAPC), .TIMEOUT(TMO),
        .FAIL_LIMIT(FLIM), .COOLDOWN(CD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .commit_hash(commit_hash),
        .commit_accept(commit_accept), .commit_backoff(commit_backoff),
        .anchor_valid(anchor_valid), .anchor_hash(anchor_hash), .anchor_last(anchor_last),
        .anchor_ready(anchor_ready), .anchor_healthy(anchor_healthy),
        .pending_count(pending_count), .batch_size(batch_size), .breaker_open(breaker_open),
        .overflow_seen(overflow_seen), .breaker_tripped(breaker_tripped)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state (modes: 0 idle, 1 sending, 2 gap, 3 open, 4 probe)
    logic [HW-1:0] mq[$];
    int mode = 0, beats = 0, waitn = 0, fails = 0, cool = 0, gapc = 0;
    int batch = BMIN;
    bit m_ovf = 0, m_trip = 0;
    int seq = 0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit cv, input bit rdy, input bit hl);
        int  n;
        bit  e_valid, e_last, e_acc, e_bo, ok, fl;
        int  old_batch;
        logic [HW-1:0] h;
        seq++;
        h = HW'(16'h5A00 + seq * 7);
        commit_valid   = cv;
        commit_hash    = h;
        anchor_ready   = rdy;
        anchor_healthy = hl;
        #1;
        n       = mq.size();
        e_valid = (mode == 1) || (mode == 4 && n > 0);
        e_last  = (mode == 4) || (mode == 1 && beats == 1);
        e_acc   = cv && (n < AL);
        e_bo    = cv && !e_acc;
        chk("R1", "commit_accept", int'(commit_accept), int'(e_acc));
        chk("R2", "commit_backoff", int'(commit_backoff), int'(e_bo));
        chk("R3", "pending_count", int'(pending_count), n);
        chk("R4", "anchor_valid", int'(anchor_valid), int'(e_valid));
        if (e_valid) begin
            chk("R3", "anchor_hash", int'(anchor_hash), int'(mq[0]));
            chk("R4", "anchor_last", int'(anchor_last), int'(e_last));
        end
        chk("R5", "batch_size", int'(batch_size), batch);
        chk("R8", "breaker_open", int'(breaker_open), int'(mode >= 3));
        chk("R2", "overflow_seen", int'(overflow_seen), int'(m_ovf));
        chk("R7", "breaker_tripped", int'(breaker_tripped), int'(m_trip));
        @(posedge clk);
        // model update from pre-edge state (R6 failure rules, R7 breaker, R8 probe)
        ok = e_valid && rdy && hl;
        fl = e_valid && ((rdy && !hl) || (!rdy && waitn == TMO - 1));
        if (!e_valid || rdy || fl) waitn = 0; else waitn++;
        old_batch = batch;
        if (n >= HWM)      batch = (batch * 2 > BMAX) ? BMAX : batch * 2;
        else if (n <= LWM) batch = BMIN;
        case (mode)
            0: if (n > 0) begin mode = 1; beats = (n < old_batch) ? n : old_batch; end
            1: begin
                if (ok) begin
                    fails = 0;
                    if (beats == 1) begin mode = 2; gapc = GAPC; end
                    else beats--;
                end else if (fl) begin
                    if (fails == FLIM - 1) begin mode = 3; cool = CD; fails = 0; m_trip = 1; end
                    else fails++;
                end
            end
            2: if (gapc == 1) mode = 0; else gapc--;
            3: if (cool == 1) mode = 4; else cool--;
            4: begin
                if (ok) mode = 0;
                else if (fl) begin mode = 3; cool = CD; m_trip = 1; end
            end
            default: mode = 0;
        endcase
        if (e_bo) m_ovf = 1;
        if (ok) void'(mq.pop_front());
        if (e_acc) mq.push_back(h);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "pending_count at reset", int'(pending_count), 0);
        chk("R9", "anchor_valid at reset", int'(anchor_valid), 0);
        chk("R9", "batch_size at reset", int'(batch_size), BMIN);
        chk("R9", "breaker_open at reset", int'(breaker_open), 0);
        chk("R9", "flags at reset", int'({overflow_seen, breaker_tripped}), 0);
        rst_n = 1'b1;

        // R1 R3 R4: trickle with healthy sink
        for (int i = 0; i < 40; i++) cyc(i % 4 == 0, 1'b1, 1'b1);
        // R2 R5: burst against a slow sink
        for (int i = 0; i < 30; i++) cyc(1'b1, i % 3 == 0, 1'b1);
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, 1'b1);
        chk("R3", "drained after burst", int'(pending_count), 0);
        chk("R2", "overflow sticky after burst", int'(overflow_seen), 1);
        // R7 R8: refusing sink trips breaker, probes fail, commits still admitted
        for (int i = 0; i < 60; i++) cyc(i % 5 == 0, 1'b1, 1'b0);
        chk("R7", "breaker tripped on refusals", int'(breaker_tripped), 1);
        chk("R7", "breaker held open", int'(breaker_open), 1);
        // R6: silent sink, timeouts
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, 1'b1);
        // R8: sink recovers, probe closes breaker, backlog drains
        for (int i = 0; i < 60; i++) cyc(i % 7 == 0, 1'b1, 1'b1);
        chk("R8", "breaker closed after good probe", int'(breaker_open), 0);
        // mixed pseudo-random traffic covering all rules
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] | lf[3], lf[5] | lf[6], !(lf[9] & lf[10]));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule